// File: doc/BRIEF.md
# Strobe RAM Host Cycle Sequencer

This block sits on the host side of a 1K x 1 static RAM. The RAM latches its address on the falling edge of an active-low enable strobe. The block takes read, write and read-modify-write commands through a valid/ready handshake. It turns each command into one strobe cycle on the enable, write-enable, address and data lines, and reports completion with a one-clock done pulse that carries the read bit. Every minimum interval of the RAM interface is given in nanoseconds as a parameter. Each one becomes a whole number of system clocks, rounded up, when the block is elaborated. A single down-counter, loaded once per phase of the state machine, times every interval.

A read-modify-write is done inside one enable-low period. The old bit is sampled once the access time has passed. Write-enable then falls, and the bit XORed with the mask bit from the command is written back. After a plain write, write-enable stays low, so a run of writes needs no write-enable pulse per word; it is raised again only when a read or read-modify-write is accepted. When the shared-bus option is set, data drive is held off for the RAM's output-disable time after the write period opens.

Top module: `strobe_ram_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, ram_en_n and ram_we_n are 1, cmd_ready is 1, rsp_done is 0 and bus_drive is 0.
- R2: A command is accepted on a clock where cmd_valid and cmd_ready are both 1. cmd_ready is 0 from the following cycle until the enable-high recovery time has passed.
- R3: ram_addr takes the command address at least one clock before ram_en_n falls and does not change while ram_en_n is 0.
- R4: Every enable-low period lasts at least ceil(180 ns / period) clocks and every enable-high period at least ceil(100 ns / period) clocks. Two consecutive enable falls are at least ceil(280 ns / period) clocks apart.
- R5: A read (cmd_op 2'b00) keeps ram_we_n at 1 for the whole enable-low period. It samples ram_dout in the last enable-low clock, which ends no earlier than ceil(180 ns / period) clocks after the fall. rsp_data then holds that bit while rsp_done is 1 for exactly one clock.
- R6: A write (cmd_op 2'b01, data in cmd_bit) holds ram_we_n low for at least ceil(100 ns / period) clocks. ram_we_n never rises while ram_en_n stays low. The written bit is driven for at least ceil(80 ns / period) clocks before the edge that ends the write period, and is kept through that edge.
- R7: After a write, ram_we_n stays 0 while the block waits for its next command. Accepting a read or read-modify-write returns ram_we_n to 1 before ram_en_n falls.
- R8: A read-modify-write (cmd_op 2'b10) uses one enable fall. It returns the old bit on rsp_data and stores old bit XOR cmd_bit.
- R9: With SHARED_BUS set, bus_drive is 1 only while both strobes are low, and never in the first ceil(120 ns / period) clocks of a write period.
- R10: cmd_op 2'b11 performs a read exactly as 2'b00 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer can take a command |
| cmd_op | input | 2 | 00 read, 01 write, 10 read-modify-write, 11 read |
| cmd_addr | input | ADDR_W | Bit address |
| cmd_bit | input | 1 | Write data, or XOR mask for read-modify-write |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_data | output | 1 | Bit read by the last read or read-modify-write |
| ram_en_n | output | 1 | RAM enable strobe, active low |
| ram_we_n | output | 1 | RAM write-enable strobe, active low |
| ram_addr | output | ADDR_W | RAM address lines |
| ram_din | output | 1 | Bit presented to the RAM data input |
| ram_dout | input | 1 | RAM data output |
| bus_drive | output | 1 | Host drives the data line during a write |

## Verification
In a read-modify-write, the edge that captures the old bit is also the edge that drops write-enable and loads the modified bit. The capture and the start of the write therefore fall on the same clock. The bench provokes this with a sweep of read-modify-writes against a RAM model. That model returns the inverted bit until the access time has passed, so a sample taken one clock early, or taken after the write begins, gives a wrong response and a wrong stored bit. A second coincidence comes in write bursts. With write-enable already low, the enable fall opens the write period in the same clock, and the bench checks that the shared-bus hold-off still counts from that clock.

// File: rtl/strobe_seq_pkg.sv
package strobe_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_E_LOW,
        ST_W_LOW,
        ST_E_HIGH
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_READ     = 2'b00,
        OP_WRITE    = 2'b01,
        OP_RMW      = 2'b10,
        OP_READ_ALT = 2'b11
    } seq_op_e;

    typedef struct packed {
        logic en_n;
        logic we_n;
    } strobe_t;

    function automatic int ns2clk(input int ns, input int period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/strobe_timer.sv
module strobe_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic [TW-1:0] count,
    output logic          zero
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - 1'b1;
    end

    assign zero = (count == '0);
endmodule

// File: rtl/strobe_bit_path.sv
module strobe_bit_path (
    input  logic clk,
    input  logic rst,
    input  logic cap_cmd,
    input  logic cmd_bit,
    input  logic cap_read,
    input  logic ram_q,
    output logic wr_bit,
    output logic rd_bit
);
    // wr_bit holds the write data or the mask; on a read capture it becomes old ^ mask
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bit <= 1'b0;
            rd_bit <= 1'b0;
        end else if (cap_cmd) begin
            wr_bit <= cmd_bit;
        end else if (cap_read) begin
            rd_bit <= ram_q;
            wr_bit <= ram_q ^ wr_bit;
        end
    end
endmodule

// File: rtl/strobe_ram_seq.sv
module strobe_ram_seq
    import strobe_seq_pkg::*;
#(
    parameter int ADDR_W        = 10,
    parameter int CLK_PERIOD_NS = 10,
    parameter bit SHARED_BUS    = 1'b0,
    parameter int T_ACC_NS      = 180,
    parameter int T_EL_NS       = 180,
    parameter int T_EH_NS       = 100,
    parameter int T_CYC_NS      = 280,
    parameter int T_WP_NS       = 100,
    parameter int T_WLEH_NS     = 100,
    parameter int T_ELWH_NS     = 100,
    parameter int T_DS_NS       = 80,
    parameter int T_OFF_NS      = 120
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_bit,
    output logic              rsp_done,
    output logic              rsp_data,
    output logic              ram_en_n,
    output logic              ram_we_n,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_din,
    input  logic              ram_dout,
    output logic              bus_drive
);
    localparam int N_ACC  = ns2clk(T_ACC_NS, CLK_PERIOD_NS);
    localparam int N_EL   = ns2clk(T_EL_NS, CLK_PERIOD_NS);
    localparam int N_EH   = ns2clk(T_EH_NS, CLK_PERIOD_NS);
    localparam int N_CYC  = ns2clk(T_CYC_NS, CLK_PERIOD_NS);
    localparam int N_WP   = ns2clk(T_WP_NS, CLK_PERIOD_NS);
    localparam int N_WLEH = ns2clk(T_WLEH_NS, CLK_PERIOD_NS);
    localparam int N_ELWH = ns2clk(T_ELWH_NS, CLK_PERIOD_NS);
    localparam int N_DS   = ns2clk(T_DS_NS, CLK_PERIOD_NS);
    localparam int N_BUSQ = SHARED_BUS ? ns2clk(T_OFF_NS, CLK_PERIOD_NS) : 0;
    localparam int N_WDAT = N_BUSQ + N_DS;
    // enable-low lengths per phase
    localparam int N_RD   = imax(imax(N_EL, N_ACC), 1);
    localparam int N_WR   = imax(imax(N_EL, N_WP), imax(imax(N_WLEH, N_ELWH), N_WDAT));
    localparam int N_WL   = imax(imax(N_WP, N_WLEH), N_WDAT);
    // enable-high state length; the setup cycle adds one more high clock
    localparam int N_EHS  = imax(imax(N_EH - 1, N_CYC - imin(N_RD, N_WR) - 1), 1);
    localparam int TW     = $clog2(imax(imax(N_RD, N_WR), imax(N_WL, N_EHS)) + 1);
    localparam logic [TW-1:0] THR_WR = TW'(N_WR - N_BUSQ);
    localparam logic [TW-1:0] THR_WL = TW'(N_WL - N_BUSQ);

    seq_state_e        state;
    seq_op_e           op_q;
    strobe_t           strb;
    logic              t_load;
    logic [TW-1:0]     t_val;
    logic [TW-1:0]     t_count;
    logic              t_zero;
    logic              cap_cmd;
    logic              cap_read;
    logic              wr_bit;
    logic              rd_bit;
    logic              done_q;
    logic [ADDR_W-1:0] addr_q;

    strobe_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .count    (t_count),
        .zero     (t_zero)
    );

    strobe_bit_path u_bits (
        .clk      (clk),
        .rst      (rst),
        .cap_cmd  (cap_cmd),
        .cmd_bit  (cmd_bit),
        .cap_read (cap_read),
        .ram_q    (ram_dout),
        .wr_bit   (wr_bit),
        .rd_bit   (rd_bit)
    );

    assign cap_cmd  = (state == ST_IDLE) && cmd_valid;
    assign cap_read = (state == ST_E_LOW) && t_zero && (op_q != OP_WRITE);

    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        case (state)
            ST_SETUP: begin
                t_load = 1'b1;
                t_val  = (op_q == OP_WRITE) ? TW'(N_WR - 1) : TW'(N_RD - 1);
            end
            ST_E_LOW: begin
                t_load = t_zero;
                t_val  = (op_q == OP_RMW) ? TW'(N_WL - 1) : TW'(N_EHS - 1);
            end
            ST_W_LOW: begin
                t_load = t_zero;
                t_val  = TW'(N_EHS - 1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            op_q      <= OP_READ;
            strb.en_n <= 1'b1;
            strb.we_n <= 1'b1;
            addr_q    <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: if (cmd_valid) begin
                    op_q   <= seq_op_e'(cmd_op);
                    addr_q <= cmd_addr;
                    if (seq_op_e'(cmd_op) != OP_WRITE)
                        strb.we_n <= 1'b1;
                    state <= ST_SETUP;
                end
                ST_SETUP: begin
                    strb.en_n <= 1'b0;
                    if (op_q == OP_WRITE)
                        strb.we_n <= 1'b0;
                    state <= ST_E_LOW;
                end
                ST_E_LOW: if (t_zero) begin
                    if (op_q == OP_RMW) begin
                        strb.we_n <= 1'b0;
                        state     <= ST_W_LOW;
                    end else begin
                        strb.en_n <= 1'b1;
                        done_q    <= 1'b1;
                        state     <= ST_E_HIGH;
                    end
                end
                ST_W_LOW: if (t_zero) begin
                    strb.en_n <= 1'b1;
                    strb.we_n <= 1'b1;
                    done_q    <= 1'b1;
                    state     <= ST_E_HIGH;
                end
                ST_E_HIGH: if (t_zero)
                    state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // data drive window: gated by the output-disable hold-off when the bus is shared
    always_comb begin
        bus_drive = 1'b0;
        if (state == ST_E_LOW && op_q == OP_WRITE)
            bus_drive = (t_count < THR_WR);
        else if (state == ST_W_LOW)
            bus_drive = (t_count < THR_WL);
    end

    assign cmd_ready = (state == ST_IDLE);
    assign rsp_done  = done_q;
    assign rsp_data  = rd_bit;
    assign ram_en_n  = strb.en_n;
    assign ram_we_n  = strb.we_n;
    assign ram_addr  = addr_q;
    assign ram_din   = wr_bit;
endmodule

// File: rtl/strobe_ram_seq_chk.sv
module strobe_ram_seq_chk
    import strobe_seq_pkg::*;
#(
    parameter int ADDR_W        = 10,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_EL_NS       = 180,
    parameter int T_EH_NS       = 100
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              rsp_done,
    input logic              ram_en_n,
    input logic              ram_we_n,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              bus_drive
);
    localparam int EL_MIN = ns2clk(T_EL_NS, CLK_PERIOD_NS);
    localparam int EH_MIN = ns2clk(T_EH_NS, CLK_PERIOD_NS);

    logic [7:0] el_cnt;
    logic [7:0] eh_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            el_cnt <= '0;
            eh_cnt <= 8'hFF;
        end else begin
            el_cnt <= ram_en_n ? 8'd0 : ((el_cnt == 8'hFF) ? el_cnt : el_cnt + 8'd1);
            eh_cnt <= !ram_en_n ? 8'd0 : ((eh_cnt == 8'hFF) ? eh_cnt : eh_cnt + 8'd1);
        end
    end

    p_ready_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    p_addr_setup_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(ram_en_n) |-> $stable(ram_addr));

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!ram_en_n && $past(!ram_en_n)) |-> $stable(ram_addr));

    p_e_low_min_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_en_n) |-> (int'(el_cnt) >= EL_MIN));

    p_e_high_min_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ram_en_n) |-> (int'(eh_cnt) >= EH_MIN));

    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    p_w_rise_with_e_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_we_n) |-> ram_en_n);

    p_drive_window_r9: assert property (@(posedge clk) disable iff (rst)
        bus_drive |-> (!ram_en_n && !ram_we_n));
endmodule

bind strobe_ram_seq strobe_ram_seq_chk #(
    .ADDR_W        (ADDR_W),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_EL_NS       (T_EL_NS),
    .T_EH_NS       (T_EH_NS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .rsp_done  (rsp_done),
    .ram_en_n  (ram_en_n),
    .ram_we_n  (ram_we_n),
    .ram_addr  (ram_addr),
    .bus_drive (bus_drive)
);

// File: tb/test_strobe_ram_seq.sv
module test_strobe_ram_seq;
    localparam int AW  = 10;
    localparam int EL  = 18;  // ceil(180/10)
    localparam int EH  = 10;  // ceil(100/10)
    localparam int CYC = 28;  // ceil(280/10)
    localparam int ACC = 18;
    localparam int WP  = 10;
    localparam int DS  = 8;
    localparam int OFF = 12;  // ceil(120/10)

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = 2'b00;
    logic [AW-1:0] cmd_addr = '0;
    logic          cmd_bit = 1'b0;
    logic          rsp_done, rsp_data;
    logic          ram_en_n, ram_we_n, ram_din, ram_dout, bus_drive;
    logic [AW-1:0] ram_addr;

    always #5 clk = ~clk;

    strobe_ram_seq #(.ADDR_W(AW), .CLK_PERIOD_NS(10), .SHARED_BUS(1'b1)) i_strobe_ram_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_bit(cmd_bit),
        .rsp_done(rsp_done), .rsp_data(rsp_data), .ram_en_n(ram_en_n),
        .ram_we_n(ram_we_n), .ram_addr(ram_addr), .ram_din(ram_din),
        .ram_dout(ram_dout), .bus_drive(bus_drive)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // ---------------- RAM model and interface monitor ----------------
    logic          mem [0:(1<<AW)-1];
    logic [AW-1:0] latched = '0, prev_addr = '0;
    logic          prev_e = 1'b1, prev_w = 1'b1, prev_wr = 1'b0, last_din = 1'b0;
    int            el = 0, eh = 1000, ff = 1000, wl = 0, wa = 0, drv = 0, falls = 0;
    bit            saw_w_low = 1'b0;
    logic [1:0]    cur_op = 2'b00;

    assign ram_dout = (!ram_en_n && ram_we_n && el >= ACC) ? mem[latched] : ~mem[latched];

    always @(negedge clk) begin
        if (!rst) begin
            if (!ram_en_n) begin
                if (prev_e) begin
                    chk(ram_addr == prev_addr, "R3 address set before enable fall", ram_addr, prev_addr);
                    chk(eh >= EH, "R4 enable high clocks", eh, EH);
                    chk(ff >= CYC, "R4 fall to fall clocks", ff, CYC);
                    latched   = ram_addr;
                    el        = 1;
                    ff        = 1;
                    falls++;
                    saw_w_low = 1'b0;
                end else begin
                    el++;
                    ff++;
                    if (ram_addr != latched)
                        chk(1'b0, "R3 address moved while enable low", ram_addr, latched);
                end
                if (!ram_we_n) saw_w_low = 1'b1;
            end else begin
                if (!prev_e) begin
                    chk(el >= EL, "R4 enable low clocks", el, EL);
                    if (cur_op[0] == cur_op[1])
                        chk(!saw_w_low, "R5 write-enable high through read", saw_w_low, 0);
                    eh = 1;
                end else begin
                    eh++;
                end
                ff++;
            end
            if (!ram_we_n) wl++;
            else begin
                if (!prev_w) chk(wl >= WP, "R6 write-enable low clocks", wl, WP);
                wl = 0;
            end
            if (!ram_en_n && !ram_we_n) begin
                wa++;
                if (bus_drive) begin
                    if (drv == 0) chk(wa > OFF, "R9 drive hold-off clocks", wa - 1, OFF);
                    drv++;
                    last_din = ram_din;
                end
            end else begin
                if (bus_drive) chk(1'b0, "R9 drive outside write period", 1, 0);
                if (prev_wr) begin
                    chk(drv >= DS, "R6 data setup clocks", drv, DS);
                    mem[latched] = last_din;
                end
                wa  = 0;
                drv = 0;
            end
            prev_wr = !ram_en_n && !ram_we_n;
        end
        prev_e    = ram_en_n;
        prev_w    = ram_we_n;
        prev_addr = ram_addr;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 190000) begin
            errors++;
            $display("FAIL R2 watchdog cycles=%0d expected below %0d", cycles, 190000);
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic pat(input int a);
        return a[0] ^ a[2] ^ a[5] ^ a[9];
    endfunction

    function automatic logic mask_of(input int a);
        return a[1] ^ a[4];
    endfunction

    function automatic int addr_of(input int i);
        return (i * 5 > 1023) ? 1023 : i * 5;
    endfunction

    task automatic issue(input logic [1:0] op, input int a, input logic b,
                         output logic rd, output int nf);
        int f0;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = a[AW-1:0];
        cmd_bit   = b;
        while (!cmd_ready) @(negedge clk);
        cur_op = op;
        f0     = falls;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(!cmd_ready, "R2 ready low after accept", cmd_ready, 0);
        while (!rsp_done) @(negedge clk);
        rd = rsp_data;
        @(negedge clk);
        chk(!rsp_done, "R5 done lasts one clock", rsp_done, 0);
        while (!cmd_ready) @(negedge clk);
        nf = falls - f0;
    endtask

    initial begin
        logic rd;
        int   nf;
        for (int k = 0; k < (1 << AW); k++) mem[k] = 1'b0;
        repeat (3) @(negedge clk);
        chk(ram_en_n && ram_we_n, "R1 strobes idle in reset", {ram_en_n, ram_we_n}, 3);
        chk(cmd_ready, "R1 ready in reset", cmd_ready, 1);
        chk(!rsp_done && !bus_drive, "R1 done and drive low in reset", {rsp_done, bus_drive}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(ram_en_n && ram_we_n && cmd_ready, "R1 idle after reset",
            {ram_en_n, ram_we_n, cmd_ready}, 7);

        // writes; write-enable kept low between them
        for (int i = 0; i <= 205; i++) begin
            issue(2'b01, addr_of(i), pat(addr_of(i)), rd, nf);
            chk(!ram_we_n, "R7 write-enable held low after write", ram_we_n, 0);
            chk(nf == 1, "R6 one enable fall per write", nf, 1);
        end
        // reads
        for (int i = 0; i <= 205; i++) begin
            issue(2'b00, addr_of(i), 1'b0, rd, nf);
            chk(rd == pat(addr_of(i)), "R5 read data", rd, pat(addr_of(i)));
            if (i == 0) chk(ram_we_n, "R7 write-enable released by read", ram_we_n, 1);
        end
        // read-modify-write
        for (int i = 0; i <= 205; i++) begin
            issue(2'b10, addr_of(i), mask_of(addr_of(i)), rd, nf);
            chk(rd == pat(addr_of(i)), "R8 old bit returned", rd, pat(addr_of(i)));
            chk(nf == 1, "R8 single enable fall", nf, 1);
        end
        // read back with alternate read code
        for (int i = 0; i <= 205; i++) begin
            issue(2'b11, addr_of(i), 1'b0, rd, nf);
            chk(rd == (pat(addr_of(i)) ^ mask_of(addr_of(i))), "R10 alternate read code after R8 update",
                rd, pat(addr_of(i)) ^ mask_of(addr_of(i)));
        end
        // write after read: write-enable falls again with the enable
        issue(2'b01, 7, 1'b1, rd, nf);
        issue(2'b00, 7, 1'b0, rd, nf);
        chk(rd == 1'b1, "R6 write after read stored", rd, 1);
        finish_run();
    end
endmodule